// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side controller that carries out the hardware part of taking an interrupt and of returning from one. It holds the program counter, status word and stack pointer. While it is idle, the execution core retires instructions into those registers. It accepts a pending request from the interrupt controller only at an instruction boundary, or at any time while the core is asleep. After accepting, it saves the return address and then the status word on a downward-growing stack in memory. It then zeroes the status word, which drops the global enable. Finally it fetches the handler address from the vector location the controller supplied and places it in the program counter.

A return strobe from the decoder runs the reverse sequence: the status word is restored first, then the program counter. If the restored status word has the sleep bit set, the core stays halted. The block reaches memory through a single-port synchronous interface with one cycle of read latency. It pulses an acknowledge to the interrupt controller at the start of each entry.

Top module: `irq_entry_seq`

## Requirements
- R1: A request (`irq_valid`) is accepted only in the idle state, only when the global enable (status bit 3) is set, and only at a boundary. A boundary is an `instr_done` pulse in the same cycle, in which case the enable comes from `sr_in`, or the sleep bit (status bit 4) being set. A request raised at any other time is ignored and the program counter is left as it was.
- R2: The first entry cycle writes the program counter to address SP-2. The second entry cycle writes the status word to SP-4. The stack pointer ends 4 lower.
- R3: After both pushes the status word becomes all zeros. A request held high through the entry is therefore not taken a second time.
- R4: `irq_ack` is high for exactly one cycle, the first entry cycle. The vector address is captured at the acceptance edge and read in the third entry cycle. The word read is in the program counter after the fourth clock edge following the acceptance edge.
- R5: While the sleep bit is set in the idle state, `core_run` and `clk_wake` are low. An accepted request raises `clk_wake` from the first entry cycle onward.
- R6: A `reti_req` pulse in the idle state reads the status word from SP and then the program counter from SP+2. The stack pointer ends 4 higher. Both registers hold the restored values after the fourth clock edge following the pulse.
- R7: After a return, `core_run` is high if the restored status word has bit 4 clear. If bit 4 is set, `core_run` and `clk_wake` stay low.
- R8: If `reti_req` and a request arrive in the same cycle, the return runs first. The request is then taken only if the restored status word enables it.
- R9: `instr_done` in the idle state loads `pc_in`, `sr_in` and `sp_in` at the next edge. When a request is accepted in that same cycle, it is the value from `pc_in` that is pushed.
- R10: After reset, the program counter equals PC_RESET, the status word is zero and the stack pointer equals SP_RESET. `core_run` is high, and neither `irq_ack` nor any memory access is active.
- R11: `core_run` is low in every cycle of an entry or return sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction retires this cycle |
| pc_in | input | W | Next-instruction address from the core |
| sr_in | input | W | Status word from the core |
| sp_in | input | W | Stack pointer from the core |
| reti_req | input | 1 | Return-from-interrupt strobe |
| irq_valid | input | 1 | Interrupt request pending |
| irq_vec | input | W | Address of the vector word |
| irq_ack | output | 1 | Request taken, one-cycle pulse |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after mem_re |
| pc | output | W | Program counter |
| sr | output | W | Status word |
| sp | output | W | Stack pointer |
| core_run | output | 1 | Core may execute instructions |
| clk_wake | output | 1 | Core clock must run |

## Verification
Two collisions are provoked. The first drives an instruction retirement and a request in the same cycle. The expected stacked address is the newly retired `pc_in` rather than the older register value, and the bench checks this in its memory model. The second drives a return strobe and a request in the same cycle. The bench confirms that no acknowledge appears while the return runs. With a frame whose status word holds enable and sleep, the acknowledge must follow in the first idle cycle and the pushed address must be the popped one. With a frame holding sleep alone, no acknowledge may appear and the core must remain halted.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_PC,
    S_PUSH_SR,
    S_VEC_RD,
    S_VEC_LD,
    S_POP_SR,
    S_POP_PC,
    S_PC_LD
  } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_valid,
  input  logic       instr_done,
  input  logic       reti_req,
  input  logic       gie_now,
  input  logic       gie_next,
  input  logic       sleep_now,
  output seq_state_e state,
  output logic       take
);
  seq_state_e nxt;
  logic gie_eff, boundary;

  assign gie_eff  = instr_done ? gie_next : gie_now;
  assign boundary = instr_done | sleep_now;
  assign take     = (state == S_IDLE) && !reti_req && irq_valid && gie_eff && boundary;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (reti_req)  nxt = S_POP_SR;
        else if (take) nxt = S_PUSH_PC;
      end
      S_PUSH_PC: nxt = S_PUSH_SR;
      S_PUSH_SR: nxt = S_VEC_RD;
      S_VEC_RD:  nxt = S_VEC_LD;
      S_VEC_LD:  nxt = S_IDLE;
      S_POP_SR:  nxt = S_POP_PC;
      S_POP_PC:  nxt = S_PC_LD;
      S_PC_LD:   nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  AST_NO_MID_INSTR: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !instr_done && !sleep_now) |=> (state != S_PUSH_PC)); // R1
  AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == S_PUSH_PC) |=> (state == S_PUSH_SR)); // R2
  AST_RETURN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && reti_req) |=> (state == S_POP_SR)); // R8
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int          W        = 16,
  parameter logic [15:0] PC_RESET = 16'hC000,
  parameter logic [15:0] SP_RESET = 16'h0400
) (
  input  logic         clk,
  input  logic         rst,
  input  seq_state_e   state,
  input  logic         instr_done,
  input  logic         reti_req,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] sr_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sr,
  output logic [W-1:0] sp
);
  localparam int          STEP   = W / 8;
  localparam logic [W-1:0] STEP_W = W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= W'(PC_RESET);
      sr <= '0;
      sp <= W'(SP_RESET);
    end else begin
      unique case (state)
        S_IDLE: begin
          if (instr_done && !reti_req) begin
            pc <= pc_in;
            sr <= sr_in;
            sp <= sp_in;
          end
        end
        S_PUSH_PC, S_PUSH_SR: sp <= sp - STEP_W;
        S_VEC_RD: sr <= '0;
        S_VEC_LD: pc <= mem_rdata;
        S_POP_SR: sp <= sp + STEP_W;
        S_POP_PC: begin
          sr <= mem_rdata;
          sp <= sp + STEP_W;
        end
        S_PC_LD: pc <= mem_rdata;
        default: ;
      endcase
    end
  end

  AST_SR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (state == S_VEC_LD) |-> (sr == '0)); // R3
  AST_STACK_DOWN: assert property (@(posedge clk) disable iff (rst)
    (state == S_PUSH_SR) |=> (sp == $past(sp) - STEP_W)); // R2
  AST_STACK_UP: assert property (@(posedge clk) disable iff (rst)
    (state == S_POP_PC) |=> (sp == $past(sp) + STEP_W)); // R6
endmodule

// File: rtl/irq_seq_memif.sv
module irq_seq_memif
  import irq_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  seq_state_e   state,
  input  logic         take,
  input  logic [W-1:0] irq_vec,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sr,
  input  logic [W-1:0] sp,
  output logic         irq_ack,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);
  localparam logic [W-1:0] STEP_W = W'(W / 8);
  logic [W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst)       vec_q <= '0;
    else if (take) vec_q <= irq_vec;
  end

  assign irq_ack = (state == S_PUSH_PC);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_PC: begin
        mem_we = 1'b1; mem_addr = sp - STEP_W; mem_wdata = pc;
      end
      S_PUSH_SR: begin
        mem_we = 1'b1; mem_addr = sp - STEP_W; mem_wdata = sr;
      end
      S_VEC_RD: begin
        mem_re = 1'b1; mem_addr = vec_q;
      end
      S_POP_SR, S_POP_PC: begin
        mem_re = 1'b1; mem_addr = sp;
      end
      default: ;
    endcase
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R4
  AST_VEC_READ: assert property (@(posedge clk) disable iff (rst)
    (state == S_PUSH_SR) |=> (mem_re && !mem_we)); // R4
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          W         = 16,
  parameter int          GIE_BIT   = 3,
  parameter int          SLEEP_BIT = 4,
  parameter logic [15:0] PC_RESET  = 16'hC000,
  parameter logic [15:0] SP_RESET  = 16'h0400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         instr_done,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] sr_in,
  input  logic [W-1:0] sp_in,
  input  logic         reti_req,
  input  logic         irq_valid,
  input  logic [W-1:0] irq_vec,
  output logic         irq_ack,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sr,
  output logic [W-1:0] sp,
  output logic         core_run,
  output logic         clk_wake
);
  seq_state_e state;
  logic       take;
  logic       idle, asleep;

  assign idle     = (state == S_IDLE);
  assign asleep   = sr[SLEEP_BIT];
  assign core_run = idle && !asleep;
  assign clk_wake = !idle || !asleep;

  irq_seq_ctrl u_ctrl (
    .clk, .rst, .irq_valid, .instr_done, .reti_req,
    .gie_now(sr[GIE_BIT]), .gie_next(sr_in[GIE_BIT]), .sleep_now(asleep),
    .state, .take
  );

  irq_seq_regs #(.W(W), .PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_regs (
    .clk, .rst, .state, .instr_done, .reti_req,
    .pc_in, .sr_in, .sp_in, .mem_rdata, .pc, .sr, .sp
  );

  irq_seq_memif #(.W(W)) u_memif (
    .clk, .rst, .state, .take, .irq_vec, .pc, .sr, .sp,
    .irq_ack, .mem_we, .mem_re, .mem_addr, .mem_wdata
  );

  AST_RUN_STALLED: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (!core_run && clk_wake)); // R11
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int W = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic instr_done = 0, reti_req = 0, irq_valid = 0;
  logic [W-1:0] pc_in = 0, sr_in = 0, sp_in = 0, irq_vec = 0;
  logic irq_ack, mem_we, mem_re, core_run, clk_wake;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, pc, sr, sp;
  logic [W-1:0] mem [0:255];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_entry_seq u0 (
    .clk, .rst, .instr_done, .pc_in, .sr_in, .sp_in, .reti_req, .irq_valid,
    .irq_vec, .irq_ack, .mem_we, .mem_re, .mem_addr, .mem_wdata, .mem_rdata,
    .pc, .sr, .sp, .core_run, .clk_wake
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[8:1]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic retire(input logic [W-1:0] p, input logic [W-1:0] s, input logic [W-1:0] st);
    @(negedge clk);
    instr_done = 1; pc_in = p; sr_in = s; sp_in = st; irq_valid = 0; reti_req = 0;
    @(negedge clk);
    instr_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 pc", pc, 16'hC000);
    chk("R10 sr", sr, 0);
    chk("R10 sp", sp, 16'h0400);
    chk("R10 run/ack/mem", {core_run, irq_ack, mem_we, mem_re}, 4'b1000);

    // Sweep: sleep x enable x boundary, two value sets each
    begin
      int iter = 0;
      for (int sl = 0; sl < 2; sl++)
        for (int g = 0; g < 2; g++)
          for (int d = 0; d < 2; d++)
            for (int rep = 0; rep < 2; rep++) begin
              logic [W-1:0] pca, pcb, sp0, srv, vec, vw, exp_pc;
              logic acc;
              int acks;
              if (sl == 1 && d == 1) continue;
              pca = 16'h4000 + W'(iter * 6);
              pcb = pca + 2;
              sp0 = 16'h01C0 - W'(iter * 8);
              srv = W'(g << 3) | W'(sl << 4) | 16'h0001 | W'(rep << 8);
              vec = 16'hFFE0 + W'(iter * 2);
              vw  = 16'hC000 + W'(iter * 16'h0104);
              mem[vec[8:1]] = vw;
              acc = (g == 1) && (d == 1 || sl == 1);
              exp_pc = (d == 1) ? pcb : pca;
              retire(pca, srv, sp0);
              // R5 sleeping core halted
              if (sl == 1) chk("R5 sleep halts", {core_run, clk_wake}, 2'b00);
              instr_done = 1'(d); pc_in = pcb; sr_in = srv; sp_in = sp0;
              irq_valid = 1; irq_vec = vec;
              acks = 0;
              for (int n = 1; n <= 5; n++) begin
                @(negedge clk);
                instr_done = 0;
                if (irq_ack) acks++;
                if (n == 1 && acc) begin
                  chk("R4 ack first cycle", irq_ack, 1);
                  chk("R5 wake on entry", clk_wake, 1);
                  chk("R11 stalled", core_run, 0);
                  chk("R2 first push addr", mem_addr, sp0 - 2);
                end
              end
              irq_valid = 0;
              if (acc) begin
                chk("R4 single ack", acks, 1);
                chk("R4 vector in pc", pc, vw);
                chk("R3 sr zero", sr, 0);
                chk("R2 sp down 4", sp, sp0 - 4);
                chk("R9 pushed pc", mem[(sp0 - 16'd2) >> 1 & 16'h00FF], exp_pc);
                chk("R2 pushed sr", mem[(sp0 - 16'd4) >> 1 & 16'h00FF], srv);
                @(negedge clk);
                reti_req = 1;
                for (int n = 1; n <= 4; n++) begin
                  @(negedge clk);
                  reti_req = 0;
                  if (n == 1) chk("R11 stalled return", core_run, 0);
                end
                chk("R6 pc restored", pc, exp_pc);
                chk("R6 sr restored", sr, srv);
                chk("R6 sp restored", sp, sp0);
                chk("R7 run after return", core_run, 1'(sl == 0));
              end else begin
                chk("R1 no ack", acks, 0);
                chk("R1 pc kept", pc, exp_pc);
                chk("R1 sp kept", sp, sp0);
              end
              iter++;
            end
    end

    // R8 collision: return and request together, frame enables + sleeps
    begin
      logic [W-1:0] sp1;
      int acks;
      sp1 = 16'h0100;
      mem[sp1[8:1]] = 16'h0018;
      mem[(sp1 + 16'd2) >> 1 & 16'h00FF] = 16'h5678;
      mem[8'hFF] = 16'hABCD;
      retire(16'h1234, 16'h0008, sp1);
      reti_req = 1; irq_valid = 1; irq_vec = 16'hFFFE;
      @(negedge clk);
      reti_req = 0;
      chk("R8 no ack during return", irq_ack, 0);
      repeat (3) @(negedge clk);
      chk("R8 pc popped", pc, 16'h5678);
      chk("R8 sr popped", sr, 16'h0018);
      @(negedge clk);
      chk("R8 ack after return", irq_ack, 1);
      repeat (4) @(negedge clk);
      irq_valid = 0;
      chk("R8 vector loaded", pc, 16'hABCD);
      chk("R8 pushed popped pc", mem[(sp1 + 16'd2) >> 1 & 16'h00FF], 16'h5678);

      // Frame with sleep only: request stays pending, core stays halted
      mem[sp1[8:1]] = 16'h0010;
      retire(16'h2000, 16'h0008, sp1);
      reti_req = 1; irq_valid = 1;
      @(negedge clk);
      reti_req = 0;
      acks = 0;
      for (int n = 2; n <= 8; n++) begin
        @(negedge clk);
        if (irq_ack) acks++;
      end
      irq_valid = 0;
      chk("R8 masked after return", acks, 0);
      chk("R7 sleep kept", {core_run, clk_wake}, 2'b00);
      chk("R6 sp after return", sp, sp1 + 4);
    end
    report();
  end
endmodule